// File: doc/BRIEF.md
# Ethernet Receive Frame Buffer with Ownership Handoff

This block sits behind a MAC that has already removed the preamble. It takes one received frame at a time from a byte stream and packs the bytes into a word-wide buffer. A small register window lets the CPU set a word index and read the frame back one 16-bit word at a time. The first byte of each byte pair sits in the low half of the word.

Hardware checks the 32-bit frame check sequence on every frame. A frame that passes is kept, and its length, not counting the four check bytes, is reported. A single ownership flag passes the buffer back and forth. The CPU hands the buffer to the hardware by setting the flag. The hardware keeps the buffer until one good frame has landed, and then it hands the buffer back by clearing the flag. The CPU has no way to pull the buffer back early.

Frames that fail the check are discarded, and so are frames that do not fit or that arrive while the CPU holds the buffer. Each such frame adds one to a saturating statistics counter.

The input stream is a valid/ready interface. `in_ready` stays high at all times, so the block never applies back-pressure. A byte is taken on every clock edge where `in_valid` is high, and the byte that has `in_last` set ends the frame. A frame that cannot be kept is still consumed in full and then dropped.

Top module: `frame_rx_buffer`

## Requirements
- R1: Right after reset, the control register (offset 2) reads 0: bit 15 is 0, so the CPU owns the buffer, and the length is 0. Offsets 0, 3, 4 and 5 also read 0, and `in_ready` is high.
- R2: Writing offset 0 sets the word index, and offset 0 reads that index back. Offset 1 returns the buffer word at that index. Frame byte 2k is in bits 7..0 and frame byte 2k+1 is in bits 15..8.
- R3: Writing offset 2 with bit 15 set, while the CPU owns the buffer, gives the buffer to the hardware. Offset 2 then reads with bit 15 set and the length unchanged.
- R4: A write to offset 2 with bit 15 clear has no effect, whoever owns the buffer. The CPU cannot take the buffer back.
- R5: A frame that is captured with a correct check sequence does three things. Bits LEN_W-1..0 of offset 2 are set to the frame's byte count minus 4, where LEN_W = log2(2*DEPTH). Bit 15 is cleared. The good-frame counter (offset 3) goes up by one. The check uses CRC-32: the reflected polynomial 0x04C11DB7, initial value all ones, and a residue of 0xC704DD7B in normal bit order over data plus check bytes. The check bytes arrive least significant byte first.
- R6: A frame whose first byte arrives while bit 15 is 0 is dropped completely. The overflow counter (offset 4) goes up by one, and the length and ownership stay unchanged.
- R7: A captured frame with a wrong check sequence adds one to the CRC-error counter (offset 5) and leaves ownership with the hardware. The next good frame is then captured normally.
- R8: A frame longer than 2*DEPTH bytes, counting its check bytes, adds one to the overflow counter and leaves ownership with the hardware. A frame of exactly 2*DEPTH bytes is accepted.
- R9: Each counter is CNT_W bits wide, is read in the low bits of its offset, holds at its all-ones value and clears on reset.
- R10: Offsets 6 and 7 read 0.
- R11: Clock edges where `in_valid` is low are ignored. Gaps between bytes do not change the stored frame, its length or its check result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream ready, always high |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of a frame |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |

## Verification
The assertions assume that the stream carries whole frames, each closed by a byte with `in_last` set, and that `in_last` matters only while `in_valid` is high. They also assume that no input is X after reset. The bench drives every input on the falling edge. Each frame it sends ends with a single last-flagged beat, and the bench inserts bubbles only between beats, never in place of the last byte. Register writes are single-cycle pulses, so a grant and a frame start can meet only in the ways the ownership rules define.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam logic [31:0] CRC_POLY_REFL    = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE_REFL = 32'hDEBB20E3; // 0xC704DD7B bit-reversed

  localparam logic [2:0] OFS_INDEX  = 3'd0;
  localparam logic [2:0] OFS_WORD   = 3'd1;
  localparam logic [2:0] OFS_CTRL   = 3'd2;
  localparam logic [2:0] OFS_GOOD   = 3'd3;
  localparam logic [2:0] OFS_OVF    = 3'd4;
  localparam logic [2:0] OFS_CRCERR = 3'd5;

  typedef enum logic [1:0] {RX_IDLE, RX_CAPTURE, RX_SKIP} rx_mode_e;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/rxb_sat_counter.sv
module rxb_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (inc && count != {W{1'b1}})
      count <= count + 1'b1;
  end
endmodule

// File: rtl/rxb_byte_ram.sv
module rxb_byte_ram #(
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wr_word,
  input  logic          wr_lane,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_word,
  output logic [15:0]   rd_data
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && wr_lane == 1'(g))
        mem[wr_word] <= wr_data;
    end
    assign rd_data[8*g +: 8] = mem[rd_word];
  end
endmodule

// File: rtl/rxb_capture.sv
module rxb_capture
  import rxb_pkg::*;
#(
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH),
  localparam int BYTES = 2 * DEPTH,
  localparam int LEN_W = $clog2(BYTES),
  localparam int BCW   = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             own_hw,
  output logic             ram_we,
  output logic [AW-1:0]    ram_word,
  output logic             ram_lane,
  output logic             done_good,
  output logic             done_crc,
  output logic             done_ovf,
  output logic [LEN_W-1:0] good_len
);
  rx_mode_e       mode, mode_now;
  logic [BCW-1:0] byte_cnt;
  logic [31:0]    crc, crc_nx;
  logic           overrun, ovr_now, full, capture, crc_ok, end_beat;

  always_comb begin
    mode_now = (mode == RX_IDLE) ? (own_hw ? RX_CAPTURE : RX_SKIP) : mode;
    capture  = in_valid && (mode_now == RX_CAPTURE);
    full     = (byte_cnt == BCW'(BYTES));
    ram_we   = capture && !full;
    ovr_now  = overrun || (capture && full);
    crc_nx   = crc_step(crc, in_data);
    crc_ok   = (crc_nx == CRC_RESIDUE_REFL) && (byte_cnt >= BCW'(3));
    end_beat = in_valid && in_last;
    done_ovf  = end_beat && ((mode_now == RX_SKIP) || ovr_now);
    done_good = end_beat && (mode_now == RX_CAPTURE) && !ovr_now && crc_ok;
    done_crc  = end_beat && (mode_now == RX_CAPTURE) && !ovr_now && !crc_ok;
  end

  assign ram_word = byte_cnt[AW:1];
  assign ram_lane = byte_cnt[0];
  assign good_len = LEN_W'(byte_cnt - BCW'(3));

  always_ff @(posedge clk) begin
    if (rst || end_beat) begin
      mode     <= RX_IDLE;
      byte_cnt <= '0;
      crc      <= '1;
      overrun  <= 1'b0;
    end else if (in_valid) begin
      mode    <= mode_now;
      overrun <= ovr_now;
      if (ram_we) begin
        byte_cnt <= byte_cnt + 1'b1;
        crc      <= crc_nx;
      end
    end
  end
endmodule

// File: rtl/frame_rx_buffer.sv
module frame_rx_buffer
  import rxb_pkg::*;
#(
  parameter  int DEPTH = 1024,
  parameter  int CNT_W = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = $clog2(2 * DEPTH)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata
);
  logic             own_hw;
  logic [LEN_W-1:0] rx_len, good_len;
  logic [AW-1:0]    rd_word, ram_word;
  logic [15:0]      ram_q;
  logic             ram_we, ram_lane, done_good, done_crc, done_ovf;
  logic [CNT_W-1:0] good_cnt, ovf_cnt, crc_cnt;

  assign in_ready = 1'b1;

  rxb_capture #(.DEPTH(DEPTH)) u_capture (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .own_hw(own_hw), .ram_we(ram_we), .ram_word(ram_word), .ram_lane(ram_lane),
    .done_good(done_good), .done_crc(done_crc), .done_ovf(done_ovf), .good_len(good_len)
  );

  rxb_byte_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .wr_word(ram_word), .wr_lane(ram_lane), .wr_data(in_data),
    .rd_word(rd_word), .rd_data(ram_q)
  );

  rxb_sat_counter #(.W(CNT_W)) u_cnt_good (.clk(clk), .rst(rst), .inc(done_good), .count(good_cnt));
  rxb_sat_counter #(.W(CNT_W)) u_cnt_ovf  (.clk(clk), .rst(rst), .inc(done_ovf),  .count(ovf_cnt));
  rxb_sat_counter #(.W(CNT_W)) u_cnt_crc  (.clk(clk), .rst(rst), .inc(done_crc),  .count(crc_cnt));

  always_ff @(posedge clk) begin
    if (rst) begin
      own_hw  <= 1'b0;
      rx_len  <= '0;
      rd_word <= '0;
    end else begin
      if (done_good) begin
        own_hw <= 1'b0;
        rx_len <= good_len;
      end else if (reg_we && reg_addr == OFS_CTRL && reg_wdata[15]) begin
        own_hw <= 1'b1;
      end
      if (reg_we && reg_addr == OFS_INDEX)
        rd_word <= reg_wdata[AW-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_INDEX:  reg_rdata[AW-1:0] = rd_word;
      OFS_WORD:   reg_rdata = ram_q;
      OFS_CTRL:   begin
                    reg_rdata[15]          = own_hw;
                    reg_rdata[LEN_W-1:0]   = rx_len;
                  end
      OFS_GOOD:   reg_rdata[CNT_W-1:0] = good_cnt;
      OFS_OVF:    reg_rdata[CNT_W-1:0] = ovf_cnt;
      OFS_CRCERR: reg_rdata[CNT_W-1:0] = crc_cnt;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int CNT_W = 16,
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_last,
  input logic             reg_we,
  input logic [2:0]       reg_addr,
  input logic             grant_bit,
  input logic             own_hw,
  input logic [LEN_W-1:0] rx_len,
  input logic [CNT_W-1:0] good_cnt,
  input logic [CNT_W-1:0] ovf_cnt,
  input logic [CNT_W-1:0] crc_cnt
);
  AST_GRANT_TAKES: assert property (@(posedge clk) disable iff (rst)
    (!own_hw && reg_we && reg_addr == 3'd2 && grant_bit) |=> own_hw); // R3

  AST_NO_RECLAIM: assert property (@(posedge clk) disable iff (rst)
    (own_hw && !(in_valid && in_last)) |=> own_hw); // R4

  AST_RELEASE_COUNTS: assert property (@(posedge clk) disable iff (rst)
    $fell(own_hw) |-> (good_cnt != $past(good_cnt) || good_cnt == {CNT_W{1'b1}})); // R5

  AST_LEN_FITS: assert property (@(posedge clk) disable iff (rst)
    $fell(own_hw) |-> ({1'b0, rx_len} <= (LEN_W + 1)'((1 << LEN_W) - 4))); // R8

  AST_CPU_OWN_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !own_hw |=> ($stable(good_cnt) && $stable(crc_cnt))); // R6

  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $countones({!$stable(good_cnt), !$stable(ovf_cnt), !$stable(crc_cnt)}) <= 1); // R7

  AST_GOOD_SAT: assert property (@(posedge clk) disable iff (rst)
    (good_cnt == {CNT_W{1'b1}}) |=> (good_cnt == {CNT_W{1'b1}})); // R9

  AST_CRC_SAT: assert property (@(posedge clk) disable iff (rst)
    (crc_cnt == {CNT_W{1'b1}}) |=> (crc_cnt == {CNT_W{1'b1}})); // R9
endmodule

bind frame_rx_buffer rxb_checker #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_rxb_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last), .reg_we(reg_we),
  .reg_addr(reg_addr), .grant_bit(reg_wdata[15]), .own_hw(own_hw), .rx_len(rx_len),
  .good_cnt(good_cnt), .ovf_cnt(ovf_cnt), .crc_cnt(crc_cnt)
);

// File: tb/test_frame_rx_buffer.sv
module test_frame_rx_buffer;
  localparam int DEPTH = 16;
  localparam int CNT_W = 4;
  localparam int BYTES = 2 * DEPTH;
  localparam logic [15:0] CMAX = 16'(2**CNT_W - 1);

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  int n_chk = 0, n_err = 0;
  logic [7:0] fbuf [0:63];
  int flen;

  always #4 clk = ~clk;

  frame_rx_buffer #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_frame_rx_buffer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); reg_we = 1'b0; reg_addr = a;
    #1 v = reg_rdata;
  endtask

  // fills fbuf with n data bytes plus a little-endian CRC-32 check field
  task automatic build(input int n, input int seed, input bit corrupt);
    logic [31:0] c;
    c = '1;
    for (int i = 0; i < n; i++) begin
      fbuf[i] = 8'((i * 37 + seed * 11 + 5) & 8'hFF);
      for (int b = 0; b < 8; b++)
        c = (c[0] ^ fbuf[i][b]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    c = ~c;
    for (int k = 0; k < 4; k++) fbuf[n + k] = c[8*k +: 8];
    if (corrupt) fbuf[0] = fbuf[0] ^ 8'h10;
    flen = n + 4;
  endtask

  task automatic send(input bit gaps);
    for (int i = 0; i < flen; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0; in_data = 8'hA5;
      end
      @(negedge clk); in_valid = 1'b1; in_data = fbuf[i]; in_last = (i == flen - 1);
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic check_words(input int n, input string req);
    logic [15:0] v;
    for (int w = 0; w < (n + 1) / 2; w++) begin
      reg_wr(3'd0, 16'(w));
      reg_rd(3'd1, v);
      if (2 * w + 1 < n) check(req, v, {fbuf[2*w+1], fbuf[2*w]});
      else check(req, {8'h00, v[7:0]}, {8'h00, fbuf[2*w]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int good;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    reg_rd(3'd2, v); check("R1 ctrl", v, 16'h0000);
    reg_rd(3'd0, v); check("R1 index", v, 16'h0000);
    reg_rd(3'd3, v); check("R1 good", v, 16'h0000);
    reg_rd(3'd4, v); check("R1 ovf", v, 16'h0000);
    reg_rd(3'd5, v); check("R1 crcerr", v, 16'h0000);
    check("R1 ready", {15'd0, in_ready}, 16'h0001);
    // R10 reserved offsets
    reg_rd(3'd6, v); check("R10 ofs6", v, 16'h0000);
    reg_rd(3'd7, v); check("R10 ofs7", v, 16'h0000);

    // R6 frame while CPU owns
    build(10, 1, 1'b0); send(1'b0);
    reg_rd(3'd4, v); check("R6 ovf", v, 16'h0001);
    reg_rd(3'd2, v); check("R6 ctrl", v, 16'h0000);
    reg_rd(3'd3, v); check("R6 good", v, 16'h0000);

    // R4 / R3 ownership handoff
    reg_wr(3'd2, 16'h0000); reg_rd(3'd2, v); check("R4 clear while cpu", v, 16'h0000);
    reg_wr(3'd2, 16'h8000); reg_rd(3'd2, v); check("R3 grant", v, 16'h8000);
    reg_wr(3'd2, 16'h0000); reg_rd(3'd2, v); check("R4 no reclaim", v, 16'h8000);
    reg_wr(3'd2, 16'h7FFF); reg_rd(3'd2, v); check("R4 no reclaim 7fff", v, 16'h8000);

    // R5 / R2 / R11 sweep over every length that fits
    good = 0;
    for (int n = 1; n <= BYTES - 4; n++) begin
      if (n > 1) reg_wr(3'd2, 16'h8000);
      build(n, n, 1'b0); send(n % 2 == 1);
      good++;
      reg_rd(3'd2, v); check("R5 R11 length", v, 16'(n));
      reg_rd(3'd3, v); check("R5 R9 good", v, (good > int'(CMAX)) ? CMAX : 16'(good));
      check_words(n, "R2 R11 word");
    end
    reg_wr(3'd0, 16'h0005); reg_rd(3'd0, v); check("R2 index readback", v, 16'h0005);

    // R7 bad check sequence
    reg_wr(3'd2, 16'h8000);
    build(12, 3, 1'b1); send(1'b0);
    reg_rd(3'd5, v); check("R7 crcerr", v, 16'h0001);
    reg_rd(3'd2, v); check("R7 still hw", v, 16'h8000 | 16'(BYTES - 4));
    build(6, 4, 1'b0); send(1'b1);
    reg_rd(3'd2, v); check("R7 next good", v, 16'h0006);
    check_words(6, "R7 data");

    // R8 overrun and exact fit
    reg_wr(3'd2, 16'h8000);
    build(BYTES - 3, 5, 1'b0); send(1'b0);
    reg_rd(3'd4, v); check("R8 ovf", v, 16'h0002);
    reg_rd(3'd2, v); check("R8 still hw", v, 16'h8006);
    build(BYTES - 4, 6, 1'b0); send(1'b0);
    reg_rd(3'd2, v); check("R8 exact fit", v, 16'(BYTES - 4));
    check_words(BYTES - 4, "R8 data");

    // R9 saturation of the CRC-error counter
    reg_wr(3'd2, 16'h8000);
    for (int k = 0; k < 14; k++) begin
      build(5, 10 + k, 1'b1); send(1'b0);
    end
    reg_rd(3'd5, v); check("R9 crcerr at max", v, CMAX);
    for (int k = 0; k < 3; k++) begin
      build(5, 30 + k, 1'b1); send(1'b0);
    end
    reg_rd(3'd5, v); check("R9 crcerr held", v, CMAX);
    reg_rd(3'd2, v); check("R9 R7 still hw", v, 16'h8000 | 16'(BYTES - 4));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule